// File: doc/BRIEF.md
# Linked Page-Table Address Translator

This block sits on the address path of a trace writer that sees its buffer as one linear address range. It turns each linear address into a physical one. In translate mode it subtracts a 1 MB-aligned input base from the address. It then selects a 1 MB sub-table by walking a doubly linked chain of 4 KB tables in memory, starting from a programmed table base. Finally it reads the 64-bit page entry for the 4 KB page and joins that page's frame number with the low 12 bits of the address. In pass-through mode the address is returned unchanged and memory is never read.

Each table holds page pointers in entries 0..255 only, so one table maps exactly 1 MB. Entry 510 (byte offset 0xFF0) links to the previous table and entry 511 (byte offset 0xFF8) links to the next one. Every entry has a frame address in bits [AW-1:12] and a valid flag in bit 0. Bits [11:1] are ignored, and so are the bits above AW-1. The block remembers the last sub-table it reached, so later walks start from that table and move one link at a time towards the target.

The request and response ports use valid/ready. A request is taken only while the block is enabled and idle, and only one translation is in flight at a time. The response stays valid and keeps its address and error flag unchanged until `rsp_ready` is high. The memory read port issues one read at a time and holds its address until `mem_rd_ready` is seen. Read data returns on a later cycle with `mem_rsp_valid` and cannot be stalled. The register port is a plain synchronous write with a combinational read, using word index `reg_addr`:
- 0: control, bit 0 enable.
- 1: mode, bit 0 (1 translate, 0 pass-through).
- 2: status, bit 0 ready and bit 1 sticky error. Writing 1 to bit 1 clears the error.
- 3: table base.
- 4: input base.

Top module: `pgchain_xlat`

## Requirements
- R1: When the block is enabled in pass-through mode, every response returns the request address with `rsp_err` low, and no memory read is issued.
- R2: In translate mode the entry for a page is read at table address + 8 × offset[19:12], where offset = address − input base. The response is {entry[AW-1:12], address[11:0]}, and entry bits [11:1] have no effect.
- R3: The sub-table number is offset >> 20. The walk follows the next link (byte 0xFF8) when moving forward and the prev link (byte 0xFF0) when moving backward, starting from the last sub-table reached. A translation therefore costs |target − current| + 1 memory reads. Each read request holds its address until it is accepted.
- R4: A page entry whose bit 0 is clear gives an error response.
- R5: A link whose bit 0 is clear gives an error response. The remembered position stays at the last table reached.
- R6: An address below the input base gives an error response in the cycle after acceptance, with no memory read.
- R7: Any error response sets status bit 1. The bit stays set until a status write with bit 1 high clears it.
- R8: Status bit 0 (ready) is low and `req_ready` is low while a translation is in flight. `req_ready` is also low while the block is disabled.
- R9: Writes to the mode, table base and input base registers have no effect while enabled.
- R10: Clearing the enable bit drops the remembered position, so the next walk starts again at sub-table 0 at the table base.
- R11: Under back-pressure, `rsp_valid`, `rsp_addr` and `rsp_err` do not change until `rsp_ready`.
- R12: The table base register stores bits [AW-1:12] and reads zero below them. The input base register stores bits [AW-1:20] and reads zero below them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | AW | Linear address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed when high with valid |
| rsp_addr | output | AW | Translated address (zero on error) |
| rsp_err | output | 1 | Translation failed |
| mem_rd_valid | output | 1 | Table read request valid |
| mem_rd_ready | input | 1 | Table read accepted |
| mem_rd_addr | output | AW | Byte address of a 64-bit table entry |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 64 | Table entry |

## Verification
The bench places four tables at scattered, non-ascending addresses and gives every valid entry non-zero filler in bits [11:1]. A design that failed to mask those bits would return wrong low address bits. Walks go forward, backward and to the same table, and the bench counts memory reads for each one. A translator that restarted every walk from the table base, or picked the wrong link slot, would show the wrong count or the wrong frame. Further cases cover an invalid trailing entry in the last table, a target beyond the end of the chain, an address below the base, a re-enable after the position was dropped, and configuration writes made while enabled. A design that got any of these wrong would either return data where an error is due or keep stale state.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_MODE  = 3'd1;
  localparam logic [2:0] REG_STAT  = 3'd2;
  localparam logic [2:0] REG_TBASE = 3'd3;
  localparam logic [2:0] REG_IBASE = 3'd4;

  // byte offsets of the link entries inside a 4 KB table
  localparam logic [11:0] OFS_PREV = 12'hFF0;
  localparam logic [11:0] OFS_NEXT = 12'hFF8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LINK,
    ST_LWAIT,
    ST_PAGE,
    ST_PWAIT,
    ST_RESP
  } walk_st_t;
endpackage

// File: rtl/pgx_regs.sv
module pgx_regs
  import pgx_pkg::*;
#(
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [63:0]   reg_wdata,
  output logic [63:0]   reg_rdata,
  input  logic          busy,
  input  logic          err_evt,
  output logic          cfg_en,
  output logic          cfg_xlate,
  output logic [AW-1:0] cfg_tbase,
  output logic [AW-1:0] cfg_ibase,
  output logic          pos_drop,
  output logic          err_flag
);
  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[63:AW], reg_wdata[11:2]};

  assign pos_drop = reg_we && (reg_addr == REG_CTRL) && !reg_wdata[0] && cfg_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_en    <= 1'b0;
      cfg_xlate <= 1'b0;
      cfg_tbase <= '0;
      cfg_ibase <= '0;
      err_flag  <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          REG_CTRL:  cfg_en <= reg_wdata[0];
          REG_MODE:  if (!cfg_en) cfg_xlate <= reg_wdata[0];
          REG_TBASE: if (!cfg_en) cfg_tbase <= {reg_wdata[AW-1:12], 12'b0};
          REG_IBASE: if (!cfg_en) cfg_ibase <= {reg_wdata[AW-1:20], 20'b0};
          default: ;
        endcase
      end
      if (err_evt)
        err_flag <= 1'b1;
      else if (reg_we && (reg_addr == REG_STAT) && reg_wdata[1])
        err_flag <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_CTRL:  reg_rdata[0] = cfg_en;
      REG_MODE:  reg_rdata[0] = cfg_xlate;
      REG_STAT:  reg_rdata[1:0] = {err_flag, !busy};
      REG_TBASE: reg_rdata[AW-1:0] = cfg_tbase;
      REG_IBASE: reg_rdata[AW-1:0] = cfg_ibase;
      default: ;
    endcase
  end
endmodule

// File: rtl/pgx_walk.sv
module pgx_walk
  import pgx_pkg::*;
#(
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_xlate,
  input  logic [AW-1:0] cfg_tbase,
  input  logic [AW-1:0] cfg_ibase,
  input  logic          pos_drop,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_err,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rsp_valid,
  input  logic [63:0]   mem_rsp_data,
  output logic          busy,
  output logic          err_evt
);
  localparam int NW = AW - 20;  // sub-table number width
  localparam int PW = AW - 12;  // page number width

  walk_st_t       st;
  logic           pos_ok;
  logic [NW-1:0]  cur_num, tgt_num;
  logic [PW-1:0]  cur_base;
  logic [7:0]     idx;
  logic [11:0]    lo12;
  logic [AW-1:0]  rsp_addr_q;
  logic           rsp_err_q;

  logic [AW-1:0]  off;
  logic           below;
  logic [PW-1:0]  base_start;
  logic [NW-1:0]  num_start, nxt_num;
  logic           fwd;
  logic           accept;

  logic unused_data;
  assign unused_data = ^{mem_rsp_data[63:AW], mem_rsp_data[11:1], cfg_tbase[11:0]};

  assign off        = req_addr - cfg_ibase;
  assign below      = req_addr < cfg_ibase;
  assign base_start = pos_ok ? cur_base : cfg_tbase[AW-1:12];
  assign num_start  = pos_ok ? cur_num : '0;
  assign fwd        = tgt_num > cur_num;
  assign nxt_num    = fwd ? cur_num + NW'(1) : cur_num - NW'(1);

  assign req_ready    = cfg_en && (st == ST_IDLE);
  assign accept       = req_valid && req_ready;
  assign busy         = (st != ST_IDLE);
  assign rsp_valid    = (st == ST_RESP);
  assign rsp_addr     = rsp_addr_q;
  assign rsp_err      = rsp_err_q;
  assign err_evt      = rsp_valid && rsp_ready && rsp_err_q;
  assign mem_rd_valid = (st == ST_LINK) || (st == ST_PAGE);
  assign mem_rd_addr  = (st == ST_PAGE) ? {cur_base, 1'b0, idx, 3'b000}
                                        : {cur_base, fwd ? OFS_NEXT : OFS_PREV};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      pos_ok     <= 1'b0;
      cur_num    <= '0;
      cur_base   <= '0;
      tgt_num    <= '0;
      idx        <= '0;
      lo12       <= '0;
      rsp_addr_q <= '0;
      rsp_err_q  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept) begin
            if (!cfg_xlate) begin
              rsp_addr_q <= req_addr;
              rsp_err_q  <= 1'b0;
              st         <= ST_RESP;
            end else if (below) begin
              rsp_addr_q <= '0;
              rsp_err_q  <= 1'b1;
              st         <= ST_RESP;
            end else begin
              tgt_num  <= off[AW-1:20];
              idx      <= off[19:12];
              lo12     <= req_addr[11:0];
              cur_base <= base_start;
              cur_num  <= num_start;
              pos_ok   <= 1'b1;
              st       <= (off[AW-1:20] == num_start) ? ST_PAGE : ST_LINK;
            end
          end
        end
        ST_LINK:  if (mem_rd_ready) st <= ST_LWAIT;
        ST_LWAIT: begin
          if (mem_rsp_valid) begin
            if (!mem_rsp_data[0]) begin
              rsp_addr_q <= '0;
              rsp_err_q  <= 1'b1;
              st         <= ST_RESP;
            end else begin
              cur_base <= mem_rsp_data[AW-1:12];
              cur_num  <= nxt_num;
              st       <= (nxt_num == tgt_num) ? ST_PAGE : ST_LINK;
            end
          end
        end
        ST_PAGE:  if (mem_rd_ready) st <= ST_PWAIT;
        ST_PWAIT: begin
          if (mem_rsp_valid) begin
            rsp_err_q  <= !mem_rsp_data[0];
            rsp_addr_q <= mem_rsp_data[0] ? {mem_rsp_data[AW-1:12], lo12} : '0;
            st         <= ST_RESP;
          end
        end
        ST_RESP:  if (rsp_ready) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
      if (pos_drop) pos_ok <= 1'b0;
    end
  end
endmodule

// File: rtl/pgchain_xlat.sv
module pgchain_xlat #(
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [63:0]   reg_wdata,
  output logic [63:0]   reg_rdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_err,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rsp_valid,
  input  logic [63:0]   mem_rsp_data
);
  logic          cfg_en, cfg_xlate, pos_drop, err_flag, busy, err_evt;
  logic [AW-1:0] cfg_tbase, cfg_ibase;

  pgx_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .err_evt(err_evt),
    .cfg_en(cfg_en), .cfg_xlate(cfg_xlate), .cfg_tbase(cfg_tbase), .cfg_ibase(cfg_ibase),
    .pos_drop(pos_drop), .err_flag(err_flag)
  );

  pgx_walk #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .cfg_en(cfg_en), .cfg_xlate(cfg_xlate), .cfg_tbase(cfg_tbase), .cfg_ibase(cfg_ibase),
    .pos_drop(pos_drop),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_err(rsp_err),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .busy(busy), .err_evt(err_evt)
  );
endmodule

// File: rtl/pgx_chk.sv
module pgx_chk #(
  parameter int AW = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [AW-1:0] rsp_addr,
  input logic          rsp_err,
  input logic          mem_rd_valid,
  input logic          mem_rd_ready,
  input logic [AW-1:0] mem_rd_addr,
  input logic          cfg_en,
  input logic          cfg_xlate,
  input logic [AW-1:0] cfg_tbase,
  input logic [AW-1:0] cfg_ibase,
  input logic          err_flag
);
  // R1: pass-through answers on the next cycle with the same address
  a_r1_pass_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cfg_xlate) |=>
      (rsp_valid && !rsp_err && rsp_addr == $past(req_addr) && !mem_rd_valid));

  // R3: a pending table read keeps its address
  a_r3_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R6: address below base fails at once
  a_r6_below_base: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cfg_xlate && req_addr < cfg_ibase) |=>
      (rsp_valid && rsp_err && !mem_rd_valid));

  // R7: error response leaves the sticky flag set
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && rsp_err) |=> err_flag);

  // R8: no new request while a table read is outstanding
  a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid || rsp_valid) |-> !req_ready);

  // R9: configuration frozen while enabled
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && reg_we) |=> ($stable(cfg_tbase) && $stable(cfg_ibase) && $stable(cfg_xlate)));

  // R11: response held under back-pressure
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_err)));
endmodule

bind pgchain_xlat pgx_chk #(.AW(AW)) u_pgx_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_err(rsp_err),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
  .cfg_en(cfg_en), .cfg_xlate(cfg_xlate), .cfg_tbase(cfg_tbase), .cfg_ibase(cfg_ibase),
  .err_flag(err_flag)
);

// File: tb/pgchain_xlat_tb_top.sv
`timescale 1ns/1ps
module pgchain_xlat_tb_top;
  localparam int AW = 40;
  localparam logic [39:0] IB = 40'h00_0010_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [63:0]   reg_wdata = '0;
  logic [63:0]   reg_rdata;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [AW-1:0] rsp_addr;
  logic          rsp_err;
  logic          mem_rd_valid;
  logic          mem_rd_ready = 1'b0;
  logic [AW-1:0] mem_rd_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [63:0]   mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  int reads  = 0;
  int exp_pos = -1;
  bit xl_mode = 1'b0;

  always #2.5 clk = ~clk;

  pgchain_xlat #(.AW(AW)) dut_i (.*);

  function automatic logic [39:0] tbl(int t);
    return 40'h12_3400_0000 + 40'(((t * 3) % 4) * 4096);
  endfunction

  function automatic logic [27:0] pn(int t, int i);
    return 28'h0A0000 + 28'(t * 1000 + i * 5);
  endfunction

  function automatic logic [63:0] mem_model(logic [39:0] a);
    logic [63:0] r;
    int e;
    r = '0;
    for (int t = 0; t < 4; t++) begin
      if (a[39:12] == tbl(t)[39:12]) begin
        e = int'(a[11:3]);
        if (e < 256) begin
          if (!(t == 3 && e >= 200)) r = {24'h0, pn(t, e), 12'h5A3};
        end else if (e == 510) begin
          if (t > 0) r = {24'h0, tbl(t - 1)} | 64'h1;
        end else if (e == 511) begin
          if (t < 3) r = {24'h0, tbl(t + 1)} | 64'h1;
        end
      end
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: random accept, 1..3 cycle read latency
  initial begin
    bit hs = 0;
    int pend = 0;
    logic [39:0] paddr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (hs) begin pend = 1 + int'($urandom % 3); hs = 0; end
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_model(paddr);
        end
      end
      mem_rd_ready = (pend == 0 && !mem_rsp_valid && !hs) ? ($urandom % 4 != 0) : 1'b0;
      if (mem_rd_ready && mem_rd_valid) begin
        hs = 1; paddr = mem_rd_addr; reads++;
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [63:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic do_xl(logic [39:0] a, string tag);
    logic [39:0] ea;
    logic ee;
    int er, r0, tgt, idx, start, dly;
    logic [39:0] off;
    logic [39:0] ha;
    logic he;
    logic [63:0] st;
    ea = '0; ee = 1'b0; er = 0;
    if (!xl_mode) ea = a;
    else if (a < IB) ee = 1'b1;
    else begin
      off = a - IB;
      tgt = int'(off >> 20);
      idx = int'(off[19:12]);
      start = (exp_pos < 0) ? 0 : exp_pos;
      if (tgt > 3) begin
        er = (3 - start) + 1; ee = 1'b1; exp_pos = 3;
      end else begin
        er = ((tgt > start) ? tgt - start : start - tgt) + 1;
        exp_pos = tgt;
        if (tgt == 3 && idx >= 200) ee = 1'b1;
        else ea = {pn(tgt, idx), a[11:0]};
      end
    end
    @(negedge clk);
    r0 = reads;
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd(3'd2, st);
    check({tag, " R8 ready low in flight"}, {63'h0, st[0]}, 64'h0);
    while (!rsp_valid) @(negedge clk);
    ha = rsp_addr; he = rsp_err;
    dly = int'($urandom % 3);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      check({tag, " R11 held"}, {23'h0, rsp_valid, rsp_err, rsp_addr}, {23'h0, 1'b1, he, ha});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check({tag, " err"}, {63'h0, he}, {63'h0, ee});
    if (!ee) check({tag, " addr"}, {24'h0, ha}, {24'h0, ea});
    check({tag, " reads"}, 64'(reads - r0), 64'(er));
  endtask

  initial begin
    logic [63:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd2, v); check("R8 reset status ready", v, 64'h1);
    rd(3'd0, v); check("R8 reset ctrl", v, 64'h0);
    check("R8 req_ready low when disabled", {63'h0, req_ready}, 64'h0);

    wr(3'd3, {24'h0, tbl(0)} | 64'hABC);
    wr(3'd4, {24'h0, IB} | 64'h5_4321);
    rd(3'd3, v); check("R12 table base aligned", v, {24'h0, tbl(0)});
    rd(3'd4, v); check("R12 input base aligned", v, {24'h0, IB});
    wr(3'd1, 64'h1); xl_mode = 1'b1;
    wr(3'd0, 64'h1);

    wr(3'd3, 64'h77_7777_7000);
    wr(3'd4, 64'h55_5550_0000);
    wr(3'd1, 64'h0);
    rd(3'd3, v); check("R9 table base frozen", v, {24'h0, tbl(0)});
    rd(3'd4, v); check("R9 input base frozen", v, {24'h0, IB});
    rd(3'd1, v); check("R9 mode frozen", v, 64'h1);

    do_xl(IB + 40'h0_0345, "R2 first page");
    do_xl(IB + 40'h2_A123, "R2 mid entry");
    do_xl(IB + 40'h2F_F9AB, "R3 forward walk");
    do_xl(IB + 40'h1A_0010, "R3 backward walk");
    do_xl(IB + 40'h1B_0FFF, "R3 same table");
    do_xl(IB + 40'h3C_7800, "R4 last valid entry");
    do_xl(IB + 40'h3C_8000, "R4 invalid entry");
    rd(3'd2, v); check("R7 sticky set", {62'h0, v[1:0]}, 64'h3);
    wr(3'd2, 64'h2);
    rd(3'd2, v); check("R7 cleared", {62'h0, v[1:0]}, 64'h1);
    do_xl(IB + 40'h50_0000, "R5 invalid link");
    do_xl(IB + 40'h3_0000, "R5 position kept");
    do_xl(IB - 40'h1, "R6 below base");
    rd(3'd2, v); check("R7 sticky after below", {63'h0, v[1]}, 64'h1);
    wr(3'd2, 64'h2);

    wr(3'd0, 64'h0); exp_pos = -1;
    wr(3'd0, 64'h1);
    do_xl(IB + 40'h22_2222, "R10 restart from base");

    wr(3'd0, 64'h0); exp_pos = -1;
    wr(3'd1, 64'h0); xl_mode = 1'b0;
    wr(3'd0, 64'h1);
    for (int k = 0; k < 10; k++)
      do_xl({8'h0, $urandom}, "R1 pass-through");

    wr(3'd0, 64'h0); exp_pos = -1;
    wr(3'd1, 64'h1); xl_mode = 1'b1;
    wr(3'd0, 64'h1);
    for (int k = 0; k < 80; k++) begin
      if ($urandom % 8 == 0) do_xl(40'($urandom % 32'h10_0000), "R6 random below");
      else do_xl(IB + 40'($urandom % 32'h60_0000), "R3 random walk");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule